// File: doc/BRIEF.md
# Dual-Register Input Capture Unit

This block timestamps transitions on an asynchronous event pin against a free-running counter value supplied from outside. The pin is brought into the functional clock domain through a synchronizer chain. An edge detector then qualifies transitions as rising, falling, or either, according to a 2-bit selector. When a qualifying transition arrives while the unit is armed, the present counter value is stored in a capture register and a sticky status flag is raised.

Two capture modes are provided. In single mode one timestamp is taken and the unit then locks. In double mode the first qualifying transition fills register 1 and the next fills register 2. Software can take the difference of the two to measure a period. After the last capture of the selected mode, every further transition is ignored until software clears the status flag with a write-one pulse. That clear re-arms the unit so that register 1 is filled next.

The block carries no streamed data. The counter value is a continuously sampled level, and the capture registers are held outputs that stay valid until the next capture. For this reason there is no valid/ready handshake and no back-pressure. Every control and status pin is a plain level, and the clear input is a one-cycle pulse.

Top module: `evcap_unit`

## Requirements
- R1: After reset, both capture registers read 0 and the status flag and interrupt are low.
- R2: The edge selector codes are 00 = no transition qualifies, 01 = rising only, 10 = falling only, 11 = both directions.
- R3: With SYNC_STAGES = 2, a pin level that is first sampled at clock edge k causes the capture register to load the counter value present at edge k+2. The status flag is set at that same edge.
- R4: In single mode (dual_mode = 0), the first qualifying transition loads capture register 1 and sets the status flag. Later transitions change neither register.
- R5: In double mode (dual_mode = 1), the first qualifying transition loads register 1 and the second loads register 2, and only double mode ever writes register 2. The status flag is set by the first capture and stays set through the second. All later transitions are ignored.
- R6: A clear pulse while the status flag is 1 drops the flag at the next edge and re-arms the unit to fill register 1 next. A qualifying transition that lands in the same cycle as such a clear is discarded. A clear pulse while the flag is 0 does nothing.
- R7: The interrupt output is high exactly when the status flag is set and irq_en is 1.
- R8: While cap_en is 0, no register is written and the sequencer returns to idle. The unit is armed one cycle after cap_en rises. If the status flag is still set at that point, it stays locked until cleared.
- R9: A pin pulse that spans a single sampling edge is seen as both a rising and a falling transition, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pin | input | 1 | Asynchronous event input |
| cnt_val | input | CNT_W | Free-running counter value to timestamp |
| cap_en | input | 1 | Capture enable; low forces the sequencer idle |
| edge_sel | input | 2 | Qualifying transition select (see R2) |
| dual_mode | input | 1 | 0 = single capture, 1 = double capture |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Write-one pulse that clears the status flag |
| cap_stat | output | 1 | Sticky capture status flag |
| cap1 | output | CNT_W | Capture register 1 |
| cap2 | output | CNT_W | Capture register 2 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: CNT_W = 32 and SYNC_STAGES = 2. The fixed two-edge latency of R3 therefore becomes an exact arithmetic expectation on the counter value. The counter starts just below its all-ones value, so captured timestamps cross the wrap. The bench sweeps all 16 combinations of edge code, capture mode and interrupt enable, with four alternating transitions in each combination. This reaches every pairing of sequencer state and transition direction. Directed cases add a clear that collides with a capture, disable and re-enable while the unit is locked, and a one-sample pulse.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT1 = 2'd1,
    ST_WAIT2 = 2'd2,
    ST_LOCK  = 2'd3
  } cap_state_e;

endpackage

// File: rtl/evcap_sync.sv
module evcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/evcap_edge.sv
module evcap_edge
  import evcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [1:0] edge_sel,
  output logic       hit
);

  logic lvl_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/evcap_ctrl.sv
module evcap_ctrl
  import evcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_en,
  input  logic             dual_mode,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic             stat
);

  cap_state_e state;
  logic       clr_fire;

  assign clr_fire = stat_clr & stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      stat  <= 1'b0;
      cap1  <= '0;
      cap2  <= '0;
    end else if (!cap_en) begin
      state <= ST_IDLE;
      if (clr_fire) stat <= 1'b0;
    end else if (clr_fire) begin
      stat  <= 1'b0;
      state <= ST_WAIT1;
    end else begin
      unique case (state)
        ST_IDLE: state <= stat ? ST_LOCK : ST_WAIT1;
        ST_WAIT1: begin
          if (hit) begin
            cap1  <= cnt_val;
            stat  <= 1'b1;
            state <= dual_mode ? ST_WAIT2 : ST_LOCK;
          end
        end
        ST_WAIT2: begin
          if (hit) begin
            cap2  <= cnt_val;
            state <= ST_LOCK;
          end
        end
        default: state <= ST_LOCK;
      endcase
    end
  end

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pin,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cap_en,
  input  logic [1:0]       edge_sel,
  input  logic             dual_mode,
  input  logic             irq_en,
  input  logic             stat_clr,
  output logic             cap_stat,
  output logic [CNT_W-1:0] cap1,
  output logic [CNT_W-1:0] cap2,
  output logic             irq
);

  logic pin_s;
  logic hit;

  evcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(evt_pin),
    .q_sync (pin_s)
  );

  evcap_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (pin_s),
    .edge_sel(edge_sel),
    .hit     (hit)
  );

  evcap_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .cnt_val  (cnt_val),
    .cap_en   (cap_en),
    .dual_mode(dual_mode),
    .stat_clr (stat_clr),
    .cap1     (cap1),
    .cap2     (cap2),
    .stat     (cap_stat)
  );

  assign irq = cap_stat & irq_en;

endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_en,
  input logic             dual_mode,
  input logic             irq_en,
  input logic             stat_clr,
  input logic             cap_stat,
  input logic [CNT_W-1:0] cap1,
  input logic [CNT_W-1:0] cap2,
  input logic             irq
);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_stat && irq_en)); // R7

  AST_CAP1_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap1 != $past(cap1)) |-> cap_stat); // R4

  AST_CAP2_DUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap2 != $past(cap2)) |-> $past(dual_mode)); // R5

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && cap_stat) |=> !cap_stat); // R6

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(cap1) && $stable(cap2))); // R8

endmodule

bind evcap_unit evcap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_en   (cap_en),
  .dual_mode(dual_mode),
  .irq_en   (irq_en),
  .stat_clr (stat_clr),
  .cap_stat (cap_stat),
  .cap1     (cap1),
  .cap2     (cap2),
  .irq      (irq)
);

// File: tb/evcap_unit_test.sv
module evcap_unit_test;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_pin;
  logic [31:0] cnt_val;
  logic        cap_en;
  logic [1:0]  edge_sel;
  logic        dual_mode;
  logic        irq_en;
  logic        stat_clr;
  logic        cap_stat;
  logic [31:0] cap1;
  logic [31:0] cap2;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] m_cap1, m_cap2;
  logic        m_stat;
  int          m_arm;

  always #5 clk = ~clk;

  evcap_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .cnt_val(cnt_val),
    .cap_en(cap_en), .edge_sel(edge_sel), .dual_mode(dual_mode),
    .irq_en(irq_en), .stat_clr(stat_clr), .cap_stat(cap_stat),
    .cap1(cap1), .cap2(cap2), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
    cnt_val = cnt_val + 32'd1;
  endtask

  task automatic chk32(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chk1(input string req, input string what,
                      input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic arm();
    tick(); stat_clr = 1'b1;
    tick(); stat_clr = 1'b0; cap_en = 1'b1;
    repeat (3) tick();
    m_stat = 1'b0;
    m_arm  = 1;
  endtask

  task automatic drive_pin(input logic lvl);
    logic rising, falling, q;
    tick();
    rising  = lvl & ~evt_pin;
    falling = ~lvl & evt_pin;
    q = (rising & edge_sel[0]) | (falling & edge_sel[1]);
    evt_pin = lvl;
    if (q && m_arm == 1) begin
      m_cap1 = cnt_val + LAT;
      m_stat = 1'b1;
      m_arm  = dual_mode ? 2 : 0;
    end else if (q && m_arm == 2) begin
      m_cap2 = cnt_val + LAT;
      m_arm  = 0;
    end
    repeat (4) tick();
  endtask

  task automatic scen(input logic [1:0] es, input logic dm, input logic ie);
    tick(); cap_en = 1'b0;
    edge_sel = es; dual_mode = dm; irq_en = ie;
    arm();
    for (int t = 0; t < 4; t++) begin
      drive_pin(~evt_pin);
      chk32(es == 2'b00 ? "R2" : "R3", "cap1", cap1, m_cap1);
      chk32(dm ? "R5" : "R4", "cap2", cap2, m_cap2);
    end
    chk1("R4", "status", cap_stat, m_stat);
    chk1("R7", "irq", irq, m_stat & ie);
  endtask

  initial begin
    logic [31:0] c;
    rst_n = 1'b0; evt_pin = 1'b0; cnt_val = 32'hFFFF_FFE0;
    cap_en = 1'b0; edge_sel = 2'b00; dual_mode = 1'b0;
    irq_en = 1'b0; stat_clr = 1'b0;
    m_cap1 = '0; m_cap2 = '0; m_stat = 1'b0; m_arm = 0;
    repeat (3) tick();
    chk32("R1", "reset cap1", cap1, 32'h0);
    chk32("R1", "reset cap2", cap2, 32'h0);
    chk1("R1", "reset status", cap_stat, 1'b0);
    chk1("R1", "reset irq", irq, 1'b0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7: full sweep of edge code x mode x interrupt enable
    for (int es = 0; es < 4; es++)
      for (int dm = 0; dm < 2; dm++)
        for (int ie = 0; ie < 2; ie++)
          scen(es[1:0], dm[0], ie[0]);

    // R6: clear while flag low has no effect
    tick(); cap_en = 1'b0; edge_sel = 2'b01; dual_mode = 1'b1; irq_en = 1'b1;
    arm();
    tick(); stat_clr = 1'b1;
    tick(); stat_clr = 1'b0;
    tick();
    chk1("R6", "idle clear status", cap_stat, 1'b0);

    // R6: clear colliding with a second capture discards it
    drive_pin(1'b1);
    chk32("R6", "first cap1", cap1, m_cap1);
    drive_pin(1'b0);
    tick(); evt_pin = 1'b1;
    tick();
    tick(); stat_clr = 1'b1;
    tick(); stat_clr = 1'b0;
    chk32("R6", "collided cap2 held", cap2, m_cap2);
    chk1("R6", "collided clear status", cap_stat, 1'b0);
    m_stat = 1'b0; m_arm = 1;
    repeat (3) tick();
    drive_pin(1'b0);
    drive_pin(1'b1);
    chk32("R6", "re-armed cap1", cap1, m_cap1);
    chk1("R6", "re-armed status", cap_stat, 1'b1);

    // R8: disabled unit captures nothing; re-enable stays locked with flag set
    tick(); cap_en = 1'b0; m_arm = 0;
    drive_pin(1'b0);
    drive_pin(1'b1);
    chk32("R8", "disabled cap1", cap1, m_cap1);
    chk32("R8", "disabled cap2", cap2, m_cap2);
    tick(); cap_en = 1'b1;
    repeat (2) tick();
    drive_pin(1'b0);
    drive_pin(1'b1);
    chk32("R8", "relocked cap1", cap1, m_cap1);
    chk32("R8", "relocked cap2", cap2, m_cap2);
    chk1("R8", "relocked status", cap_stat, 1'b1);
    drive_pin(1'b0);

    // R9: one-sample pulse seen as a falling transition one cycle later
    tick(); cap_en = 1'b0; edge_sel = 2'b10; dual_mode = 1'b0;
    arm();
    tick(); evt_pin = 1'b1; c = cnt_val;
    tick(); evt_pin = 1'b0;
    repeat (5) tick();
    chk32("R9", "pulse fall cap1", cap1, c + 32'd1 + LAT);
    chk1("R9", "pulse status", cap_stat, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule